// File: doc/BRIEF.md
# Serial PHY Management Bus Master

This block drives the two-wire management bus used to configure Ethernet PHYs. Software programs a 16-bit control word and a 16-bit data word through a simple synchronous register port. It then starts a transaction by writing the control word with its busy bit set. The controller derives a management clock (`mdc`) from the system clock, using a divider picked by an encoded clock-range field. It shifts a complete management frame onto the data line through a tristate output enable. On a read, it captures the 16 bits the PHY returns.

No acknowledge ever comes back from the PHY, so completion has one meaning only: the controller clears the busy bit. A frame therefore takes the same time whether a PHY answers or not. If no PHY is present, a read returns whatever the pulled-up line holds. While a transaction is in flight, register writes are dropped. The operands stay frozen until busy falls.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word and the data word both read as zero, `mdc` is low and `mdio_oe` is low.
- R2: `reg_sel`=0 selects the control word and `reg_sel`=1 selects the data word. Control fields: bit 0 busy, bit 1 direction (1 write, 0 read), bits 5:2 clock-range code, bits 10:6 PHY register address, bits 15:11 PHY device address. The data word is 16 bits. Read bits 31:16 are always zero.
- R3: Writing the control word with bit 0 set launches a frame. Busy stays set for exactly 64 MDC periods and clears on the last falling edge of `mdc`.
- R4: A write frame drives, MSB first and one bit per MDC period, with `mdio_oe` high throughout: 32 ones, 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10, then the 16 data bits.
- R5: A read frame drives 32 ones, 01, opcode 10 and the two addresses. It then holds `mdio_oe` low for the last 18 bits. The last 16 bits are sampled on rising edges of `mdc`, MSB first, and are placed in the data word when busy clears.
- R6: Clock-range code 4'b0011 gives an MDC period of 26 system clocks. Code 4'b0000, and every other code, gives 42. High and low phases are each half the period.
- R7: While a frame runs, `mdio_o` changes only at falling edges of `mdc`.
- R8: While busy is set, writes to either register are ignored. Control fields and data keep their values.
- R9: A read with no PHY driving the line completes in the same time and returns 16'hFFFF.
- R10: When no frame is running, `mdc` is held low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 control word, 1 data word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions assume that the data line input is resolved: it follows `mdio_o` while the enable is high, and otherwise a PHY or a pull-up gives it a defined level. The bench builds the line that way from the output enable, a PHY model and a pull-up default. They also assume that software writes come only as single-cycle strobes with a defined `reg_sel`. The bench keeps to this by driving all register traffic on the falling clock edge through one task. It injects its only writes during busy on purpose, to show that they are dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [3:0] CODE_FAST = 4'b0011;

  // busy at bit 0 (last field of a packed struct is the LSB)
  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regad;
    logic [3:0] clk_sel;
    logic       is_wr;
    logic       busy;
  } ctrl_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic wr, input logic [4:0] phy, input logic [4:0] regad,
    input logic [15:0] d);
    return {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, regad,
            (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] half,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             term;

  assign term = (cnt_q == half - CNT_W'(1));
  assign rise = en && term && !mdc_q;
  assign fall = en && term && mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R6: the phase counter never passes the selected half period
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < half));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_write,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rd_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic                 active_q, active_d;
  logic                 wr_q, wr_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic [15:0]          cap_q, cap_d;

  assign mdio_o  = sr_q[FRAME_LEN-1];
  assign mdio_oe = active_q && (wr_q || (idx_q < TA_IDX));
  assign done    = active_q && fall && (idx_q == LAST_IDX);
  assign rd_data = cap_q;

  always_comb begin
    active_d = active_q;
    wr_d     = wr_q;
    idx_d    = idx_q;
    sr_d     = sr_q;
    cap_d    = cap_q;
    if (start) begin
      active_d = 1'b1;
      wr_d     = is_write;
      idx_d    = '0;
      sr_d     = build_frame(is_write, phy, regad, wdata);
    end else if (active_q) begin
      if (rise && !wr_q && (idx_q >= DATA_IDX))
        cap_d = {cap_q[14:0], mdio_i};
      if (fall) begin
        if (idx_q == LAST_IDX) begin
          active_d = 1'b0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
          sr_d  = {sr_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      idx_q    <= '0;
      sr_q     <= '0;
      cap_q    <= '0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr_d;
      idx_q    <= idx_d;
      sr_q     <= sr_d;
      cap_q    <= cap_d;
    end
  end

  // R7: line value moves only on an MDC falling edge while a frame runs
  p_change_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active_q) && active_q && !$past(fall)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_SLOW = 42,
  parameter int DIV_FAST = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CNT_W = $clog2(DIV_SLOW / 2 + 1);

  logic        rst_meta, rst_s;
  ctrl_t       ctrl_q, ctrl_d;
  logic [15:0] data_q, data_d;
  logic        launch;
  logic        rise_tick, fall_tick, frame_done;
  logic [15:0] rd_data;
  logic [CNT_W-1:0] half_sel;
  logic        unused_hi;

  assign unused_hi = ^reg_wdata[31:16];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  assign half_sel = (ctrl_q.clk_sel == CODE_FAST) ? CNT_W'(DIV_FAST / 2)
                                                  : CNT_W'(DIV_SLOW / 2);

  always_comb begin
    ctrl_d = ctrl_q;
    data_d = data_q;
    launch = 1'b0;
    if (ctrl_q.busy) begin
      if (frame_done) begin
        ctrl_d.busy = 1'b0;
        if (!ctrl_q.is_wr) data_d = rd_data;
      end
    end else if (reg_we) begin
      if (!reg_sel) begin
        ctrl_d = ctrl_t'(reg_wdata[15:0]);
        launch = reg_wdata[0];
      end else begin
        data_d = reg_wdata[15:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
    end
  end

  assign reg_rdata = reg_sel ? {16'h0, data_q} : {16'h0, ctrl_q};

  mdio_clkdiv #(.CNT_W(CNT_W)) u_clkdiv (
    .clk  (clk),
    .rst_n(rst_s),
    .en   (ctrl_q.busy),
    .half (half_sel),
    .mdc  (mdc),
    .rise (rise_tick),
    .fall (fall_tick)
  );

  mdio_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_s),
    .start   (launch),
    .is_write(ctrl_d.is_wr),
    .phy     (ctrl_d.phy),
    .regad   (ctrl_d.regad),
    .wdata   (data_q),
    .rise    (rise_tick),
    .fall    (fall_tick),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (frame_done),
    .rd_data (rd_data)
  );

  // R10: idle bus is quiet
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !ctrl_q.busy |-> (!mdc && !mdio_oe));
  // R3: busy falls only on an MDC falling edge
  p_busy_ends_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(ctrl_q.busy) |-> $past(fall_tick));
  // R8: writes during busy leave registers untouched
  p_ignore_busy_write_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (ctrl_q.busy && reg_we && !frame_done) |=>
      ($stable(data_q) && $stable(ctrl_q[15:1])));
  // R5: line released during a read turnaround and data phase
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (ctrl_q.busy && !ctrl_q.is_wr && $past(ctrl_q.busy) && !mdio_oe) |=>
      (!mdio_oe || !ctrl_q.busy));
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  import mdio_pkg::*;

  typedef struct {
    bit        wr;
    bit [4:0]  phy;
    bit [4:0]  ra;
    bit [15:0] data;
    bit        present;
  } item_t;

  logic        clk, rst_n, reg_we, reg_sel, mdio_i;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  int          tests, fails;
  item_t       q[$];
  int          rise_cnt;
  logic [63:0] obs_v, obs_oe;
  logic        phy_drv, phy_bit;
  time         t_rise, last_period, high_time;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(item_t it);
    return {32'hFFFFFFFF, 2'b01, (it.wr ? 2'b01 : 2'b10), it.phy, it.ra,
            (it.wr ? 2'b10 : 2'b11), (it.wr ? it.data : 16'hFFFF)};
  endfunction

  // monitor / PHY model / scoreboard
  always @(posedge mdc) begin
    if (q.size() == 0) begin
      tests++; fails++;
      $display("FAIL R4 actual=frame expected=no frame");
    end else begin
      item_t it;
      it = q[0];
      if (rise_cnt > 0) last_period = $time - t_rise;
      t_rise = $time;
      obs_v[63-rise_cnt]  = mdio_o;
      obs_oe[63-rise_cnt] = mdio_oe;
      rise_cnt++;
      if (!it.wr && it.present && rise_cnt >= 48 && rise_cnt <= 63) begin
        phy_drv = 1'b1;
        phy_bit = it.data[63-rise_cnt];
      end else begin
        phy_drv = 1'b0;
      end
      if (rise_cnt == 64) begin
        if (it.wr) begin
          check("R4 oe", obs_oe, 64'hFFFF_FFFF_FFFF_FFFF);
          check("R4 bits", obs_v, exp_frame(it));
        end else begin
          check("R5 oe", obs_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
          check("R5 bits", {obs_v[63:18], 18'h0}, {exp_frame(it) >> 18, 18'h0});
        end
        void'(q.pop_front());
        rise_cnt = 0;
      end
    end
  end

  always @(negedge mdc) high_time = $time - t_rise;

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic run_txn(input bit wr, input bit [4:0] phy, input bit [4:0] ra,
                         input bit [15:0] d, input bit [3:0] code,
                         input bit present, input bit poke);
    item_t it;
    int div, cnt;
    logic [31:0] rd;
    logic [15:0] cw;
    div = (code == 4'b0011) ? 26 : 42;
    it.wr = wr; it.phy = phy; it.ra = ra; it.data = d; it.present = present;
    if (wr) reg_write(1'b1, {16'h0, d});
    q.push_back(it);
    cw = {phy, ra, code, wr, 1'b1};
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = {16'h0, cw};
    @(negedge clk);
    reg_we = 1'b0;
    cnt = 0;
    while (reg_rdata[0] === 1'b1) begin
      cnt++;
      if (poke && cnt == 100) begin
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_7FFE;
      end else if (poke && cnt == 101) begin
        reg_sel = 1'b1; reg_wdata = 32'h0000_FFFF;
      end else if (poke && cnt == 102) begin
        reg_we = 1'b0; reg_sel = 1'b0;
      end
      @(negedge clk);
    end
    check("R3 busy length", 64'(cnt), 64'(64 * div));
    check("R6 period", 64'(last_period), 64'(div * 10));
    check("R6 high phase", 64'(high_time), 64'(div * 5));
    check("R10 mdc idle", {63'h0, mdc}, 64'h0);
    check("R10 oe idle", {63'h0, mdio_oe}, 64'h0);
    reg_read(1'b0, rd);
    check(poke ? "R8 ctrl kept" : "R3 ctrl after", 64'(rd), 64'({cw[15:1], 1'b0}));
    reg_read(1'b1, rd);
    if (wr)
      check(poke ? "R8 data kept" : "R4 data kept", 64'(rd), 64'(d));
    else if (present)
      check("R5 read data", 64'(rd), 64'(d));
    else
      check("R9 absent read", 64'(rd), 64'h0000_FFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    tests = 0; fails = 0; rise_cnt = 0;
    phy_drv = 1'b0; phy_bit = 1'b1;
    t_rise = 0; last_period = 0; high_time = 0;
    reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    // R1
    reg_read(1'b0, rd); check("R1 ctrl", 64'(rd), 64'h0);
    reg_read(1'b1, rd); check("R1 data", 64'(rd), 64'h0);
    check("R1 mdc", {63'h0, mdc}, 64'h0);
    check("R1 oe", {63'h0, mdio_oe}, 64'h0);
    // R2: fields and reserved bits, busy clear so no frame
    reg_write(1'b0, 32'hABCD_0000 | {16'h0, 5'h15, 5'h0A, 4'h3, 1'b1, 1'b0});
    reg_read(1'b0, rd);
    check("R2 ctrl fields", 64'(rd), 64'({16'h0, 5'h15, 5'h0A, 4'h3, 1'b1, 1'b0}));
    reg_write(1'b1, 32'h5A5A_1234);
    reg_read(1'b1, rd);
    check("R2 data reserved", 64'(rd), 64'h0000_1234);
    check("R10 no frame", {63'h0, mdc}, 64'h0);
    // transactions
    run_txn(1'b1, 5'h01, 5'h04, 16'hA5C3, 4'b0000, 1'b1, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h11, 16'h3C96, 4'b0011, 1'b1, 1'b0);
    run_txn(1'b0, 5'h02, 5'h00, 16'h0000, 4'b0101, 1'b0, 1'b0);
    run_txn(1'b1, 5'h00, 5'h1F, 16'h0F0F, 4'b0011, 1'b1, 1'b1);
    run_txn(1'b0, 5'h0B, 5'h03, 16'h8001, 4'b0000, 1'b1, 1'b0);
    check("R4 scoreboard empty", 64'(q.size()), 64'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule